// File: doc/BRIEF.md
# Presettable Split Ripple Binary Counter

A four-bit up-counter made of two sections that have separate clocks. The low section is a single toggle stage that advances on each falling edge of `tick_a`. The high section is a three-stage ripple chain that advances on each falling edge of `tick_b`. Inside the high section, every stage is clocked by the falling edge of the stage below it. If the system ties `tick_b` to `cnt[0]`, the two sections form one modulo-16 binary counter. Used apart, they give a divide-by-two and a divide-by-eight.

Two active-low controls act at once, with no clock. `clear_n` empties every stage and wins over everything else. `load_n` forces the stages to the values on `din`. While `load_n` stays low, the outputs follow `din`. When it goes high, the last value is kept. This lets the block serve as a four-bit transparent latch as well as a programmable counter. Each stage is a flip-flop with asynchronous set and clear. A load drives set from the data bit and clear from its inverse.

Top module: `ripple_split_counter`

## Requirements
- R1: While `clear_n` is low, `cnt` is 0000. This takes effect when `clear_n` falls, with no clock edge.
- R2: `clear_n` low overrides `load_n` and both tick inputs: with both controls low and ticks pulsed, `cnt` stays 0000.
- R3: With `clear_n` high, a low `load_n` copies `din[i]` into `cnt[i]` for every bit at once, with no clock edge. This includes the moment `clear_n` is released while `load_n` is still low.
- R4: While `load_n` is low, `cnt` follows every change of `din`, and falling edges on `tick_a` or `tick_b` have no effect on `cnt`.
- R5: When `load_n` returns high, `cnt` keeps the last value loaded, and later changes of `din` do not alter it.
- R6: With both controls high, each falling edge of `tick_a` inverts `cnt[0]`. Rising edges of `tick_a` change nothing, and `tick_a` never alters `cnt[3:1]`.
- R7: With both controls high, each falling edge of `tick_b` adds one, modulo 8, to the three-bit value `cnt[3:1]`, with `cnt[1]` as its least significant bit. `cnt[0]` is not affected.
- R8: With `tick_b` tied to `cnt[0]`, successive falling edges of `tick_a` step `cnt` through 0 to 15 in binary order, and the step after 15 gives 0.
- R9: Counting resumes from the forced value after a clear or load in the middle of a count ends: from 0 after a clear, from the loaded value after a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tick_a | input | 1 | Falling-edge clock of the low (divide-by-two) section |
| tick_b | input | 1 | Falling-edge clock of the high (divide-by-eight) section |
| clear_n | input | 1 | Asynchronous clear, active low, highest priority |
| load_n | input | 1 | Asynchronous parallel load / latch enable, active low |
| din | input | 4 | Parallel data, bit i goes to `cnt[i]` |
| cnt | output | 4 | Stage outputs; bit 0 is the low section, bits 3:1 the high section |

## Verification
Every stage is visible directly on `cnt`, so a wrong stage value shows at the next sample after the edge or control change that caused it. Only in cascaded counting can an error stay hidden until a later carry: a stage whose clock edge was missed keeps its stale value, and the sequence drifts from the binary order one step later. The cascaded test compares every one of the sixteen states and the wrap, which catches a fault in any stage at the first transition where that stage should change. Latch and clear faults appear immediately, because the bench samples `cnt` right after each control or data change.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int unsigned LO_BITS_DEF = 1;
    localparam int unsigned HI_BITS_DEF = 3;

    // Which asynchronous action, if any, is applied to the stages
    typedef enum logic [1:0] {
        MODE_CLEAR = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_COUNT = 2'd2
    } mode_e;

    // Active-low asynchronous controls of one stage flip-flop
    typedef struct packed {
        logic set_n;
        logic clr_n;
    } force_t;

    function automatic mode_e decode_mode(logic clear_n, logic load_n);
        if (!clear_n) return MODE_CLEAR;
        if (!load_n)  return MODE_LOAD;
        return MODE_COUNT;
    endfunction

    function automatic force_t force_ctrl(mode_e mode, logic d);
        force_t f;
        case (mode)
            MODE_CLEAR: begin f.set_n = 1'b1; f.clr_n = 1'b0; end
            MODE_LOAD:  begin f.set_n = ~d;   f.clr_n = d;    end
            default:    begin f.set_n = 1'b1; f.clr_n = 1'b1; end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rsc_cell.sv
module rsc_cell (
    input  logic clk,
    input  logic clr_n,
    input  logic set_n,
    output logic q
);

    // Toggle stage: falling-edge clock, clear dominates set
    always_ff @(negedge clk or negedge clr_n or negedge set_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else if (!set_n) begin
            q <= 1'b1;
        end else begin
            q <= ~q;
        end
    end

endmodule

// File: rtl/rsc_chain.sv
module rsc_chain
    import rsc_pkg::*;
#(
    parameter int unsigned BITS = 3
) (
    input  logic            clk,
    input  logic            clear_n,
    input  logic            load_n,
    input  logic [BITS-1:0] din,
    output logic [BITS-1:0] q
);

    mode_e                 mode;
    force_t [BITS-1:0]     ctl;
    logic   [BITS-1:0]     stage_clk;

    assign mode = decode_mode(clear_n, load_n);

    for (genvar i = 0; i < BITS; i++) begin : g_stage
        assign ctl[i] = force_ctrl(mode, din[i]);

        if (i == 0) begin : g_head
            assign stage_clk[i] = clk;
        end else begin : g_link
            assign stage_clk[i] = q[i-1];
        end

        rsc_cell u_cell (
            .clk   (stage_clk[i]),
            .clr_n (ctl[i].clr_n),
            .set_n (ctl[i].set_n),
            .q     (q[i])
        );
    end

    // R2: a section clock edge during clear finds the section empty
    assert_clear_wins_R2: assert property (
        @(negedge clk) disable iff (clear_n)
        1'b1 |-> q == '0
    ) else $error("section not empty under clear");

    // R4: a section clock edge during load leaves the section equal to its data
    assert_load_track_R4: assert property (
        @(negedge clk) disable iff (!clear_n || load_n)
        1'b1 |-> q == din
    ) else $error("section left data while loading");

endmodule

// File: rtl/ripple_split_counter.sv
module ripple_split_counter
    import rsc_pkg::*;
#(
    parameter int unsigned LO_BITS = LO_BITS_DEF,
    parameter int unsigned HI_BITS = HI_BITS_DEF
) (
    input  logic                       tick_a,
    input  logic                       tick_b,
    input  logic                       clear_n,
    input  logic                       load_n,
    input  logic [LO_BITS+HI_BITS-1:0] din,
    output logic [LO_BITS+HI_BITS-1:0] cnt
);

    localparam int unsigned WIDTH = LO_BITS + HI_BITS;

    rsc_chain #(.BITS(LO_BITS)) u_lo (
        .clk     (tick_a),
        .clear_n (clear_n),
        .load_n  (load_n),
        .din     (din[LO_BITS-1:0]),
        .q       (cnt[LO_BITS-1:0])
    );

    rsc_chain #(.BITS(HI_BITS)) u_hi (
        .clk     (tick_b),
        .clear_n (clear_n),
        .load_n  (load_n),
        .din     (din[WIDTH-1:LO_BITS]),
        .q       (cnt[WIDTH-1:LO_BITS])
    );

    // R1: leaving clear, all stages are empty
    assert_release_zero_R1: assert property (
        @(posedge clear_n) disable iff (!load_n)
        1'b1 |-> cnt == '0
    ) else $error("counter not empty at clear release");

    // R5: closing the latch, the stages hold the data present
    assert_latch_close_R5: assert property (
        @(posedge load_n) disable iff (!clear_n)
        1'b1 |-> cnt == din
    ) else $error("latch closed on wrong value");

endmodule

// File: tb/ripple_split_counter_test.sv
`timescale 1ns/1ps
module ripple_split_counter_test;

    // 250 MHz bench clock paces the stimulus; the block itself is
    // rated for tick rates near 70 MHz, which this bench does not model.
    logic       clk = 1'b0;
    logic       tick_a = 1'b1;
    logic       tick_b_drv = 1'b1;
    logic       cascade = 1'b0;
    logic       clear_n = 1'b1;
    logic       load_n = 1'b1;
    logic [3:0] din = 4'h0;
    logic       tick_b;
    logic [3:0] cnt;

    int vectors = 0;
    int errors  = 0;

    always #2 clk = ~clk;

    assign tick_b = cascade ? cnt[0] : tick_b_drv;

    ripple_split_counter uut (
        .tick_a  (tick_a),
        .tick_b  (tick_b),
        .clear_n (clear_n),
        .load_n  (load_n),
        .din     (din),
        .cnt     (cnt)
    );

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        vectors++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: cnt=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic pulse_a();
        @(posedge clk) tick_a = 1'b0;
        @(posedge clk) tick_a = 1'b1;
        settle();
    endtask

    task automatic pulse_b();
        @(posedge clk) tick_b_drv = 1'b0;
        @(posedge clk) tick_b_drv = 1'b1;
        settle();
    endtask

    task automatic do_load(input logic [3:0] v);
        @(posedge clk) begin din = v; load_n = 1'b0; end
        @(posedge clk) load_n = 1'b1;
        settle();
    endtask

    task automatic test_clear();
        @(posedge clk) clear_n = 1'b0;
        settle();
        check("R1 clear at start", cnt, 4'h0);
        @(posedge clk) clear_n = 1'b1;
        do_load(4'hA);
        check("R3 load 1010", cnt, 4'hA);
        @(posedge clk) clear_n = 1'b0;
        settle();
        check("R1 clear from 1010 without clock", cnt, 4'h0);
        @(posedge clk) clear_n = 1'b1;
        settle();
    endtask

    task automatic test_priority();
        @(posedge clk) begin clear_n = 1'b0; load_n = 1'b0; din = 4'hF; end
        settle();
        check("R2 clear over load", cnt, 4'h0);
        pulse_a();
        pulse_b();
        check("R2 clear over ticks", cnt, 4'h0);
        @(posedge clk) clear_n = 1'b1;
        settle();
        check("R3 load takes over at clear release", cnt, 4'hF);
        @(posedge clk) load_n = 1'b1;
        settle();
    endtask

    task automatic test_latch();
        @(posedge clk) begin din = 4'h3; load_n = 1'b0; end
        settle();
        check("R4 follow 0011", cnt, 4'h3);
        @(posedge clk) din = 4'hC;
        settle();
        check("R4 follow 1100", cnt, 4'hC);
        pulse_a();
        pulse_b();
        check("R4 ticks ignored while loading", cnt, 4'hC);
        @(posedge clk) din = 4'h9;
        settle();
        check("R4 follow 1001", cnt, 4'h9);
        @(posedge clk) load_n = 1'b1;
        settle();
        check("R5 hold at release", cnt, 4'h9);
        @(posedge clk) din = 4'h6;
        settle();
        check("R5 data change ignored after release", cnt, 4'h9);
    endtask

    task automatic test_low();
        do_load(4'h0);
        @(posedge clk) tick_a = 1'b0;
        settle();
        check("R6 low section on falling edge", cnt, 4'h1);
        @(posedge clk) tick_a = 1'b1;
        settle();
        check("R6 rising edge no effect", cnt, 4'h1);
        pulse_a();
        check("R6 low section toggles back", cnt, 4'h0);
        pulse_a();
        check("R6 high section untouched", cnt, 4'h1);
    endtask

    task automatic test_high();
        do_load(4'h1);
        for (int k = 1; k <= 9; k++) begin
            pulse_b();
            check("R7 high section step", cnt, {3'(k % 8), 1'b1});
        end
    endtask

    task automatic test_cascade();
        @(posedge clk) clear_n = 1'b0;
        @(posedge clk) cascade = 1'b1;
        @(posedge clk) clear_n = 1'b1;
        settle();
        check("R8 cascade start", cnt, 4'h0);
        for (int k = 1; k <= 17; k++) begin
            pulse_a();
            check("R8 modulo-16 step", cnt, 4'(k % 16));
        end
        // now at 1; step to 6 (low bit clear) before a clear mid-count
        for (int k = 0; k < 5; k++) pulse_a();
        check("R8 reach 6", cnt, 4'h6);
        @(posedge clk) clear_n = 1'b0;
        settle();
        check("R1 clear mid-count", cnt, 4'h0);
        @(posedge clk) clear_n = 1'b1;
        for (int k = 0; k < 3; k++) pulse_a();
        check("R9 resume after clear", cnt, 4'h3);
        pulse_a();
        check("R8 reach 4", cnt, 4'h4);
        do_load(4'hA);
        check("R3 load mid-count", cnt, 4'hA);
        pulse_a();
        pulse_a();
        check("R9 resume after load", cnt, 4'hC);
        @(posedge clk) clear_n = 1'b0;
        @(posedge clk) cascade = 1'b0;
        @(posedge clk) clear_n = 1'b1;
        settle();
    endtask

    initial begin
        test_clear();
        test_priority();
        test_latch();
        test_low();
        test_high();
        test_cascade();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: cnt=%h expected=finished run", cnt);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule